// File: doc/BRIEF.md
# LPC Cycle SYNC Tracker

This block watches one transaction on a 4-bit multiplexed low-pin-count host bus, one nibble at a time, from the host side. A one-clock frame-start strobe opens a cycle. The tracker then takes the first header nibble as the cycle kind and direction, and the second header nibble as the transfer size. It checks both for legality. After that it reads the SYNC nibbles returned by the peripheral. It counts short waits against a limit and lets long waits run on. When a SYNC code ends the cycle, or the header is illegal, or the short waits run out, it reports a single outcome.

The tracker only observes the bus. The nibble stream is qualified by `phase_i`, and there is no ready signal: the tracker takes every qualified nibble in the cycle it is presented. Back-pressure cannot be applied, because the bus itself never stalls for the observer. Each outcome is announced by a one-clock `done_o` pulse. `status_o`, `cyc_kind_o`, `cyc_write_o` and `size_o` then hold until the next frame start, which clears them.

Top module: `lpc_sync_tracker`

## Requirements
- R1: After reset, `status_o` is 0 (none), `done_o` is 0, and `cyc_kind_o`, `cyc_write_o` and `size_o` are 0.
- R2: The first header nibble after a frame start sets `cyc_kind_o` to its bits[3:2] (0 = I/O, 1 = memory, 2 = DMA) and `cyc_write_o` to its bit 1 (1 = write). Both are visible in the clock after the nibble is sampled.
- R3: If that nibble has bits[3:2] = 3 or bit 0 = 1, the cycle ends in the next clock with `status_o` = 5 (abort) and a `done_o` pulse. The size nibble and the SYNC nibbles are not awaited.
- R4: The second header nibble sets `size_o` to its bits[1:0]; bits[3:2] are ignored. If bits[1:0] = 2, the cycle ends with `status_o` = 5 (abort).
- R5: SYNC nibble 0x0 ends the cycle with `status_o` = 1 (ready).
- R6: SYNC nibble 0x9 ends the cycle with `status_o` = 2 (ready, more DMA wanted) when `cyc_kind_o` = 2. On any other kind it ends the cycle with `status_o` = 4 (protocol error).
- R7: SYNC nibble 0xA ends the cycle with `status_o` = 3 (error reported by the peripheral).
- R8: Any SYNC nibble other than 0x0, 0x5, 0x6, 0x9 and 0xA ends the cycle with `status_o` = 4 (protocol error).
- R9: SYNC 0x5 (short wait) and 0x6 (long wait) do not end the cycle. The SHORT_WAIT_LIMIT-th short wait (8 by default) counted since the last long wait or the start of SYNC ends the cycle with `status_o` = 6 (timeout). A long wait clears that count, so long waits never time out.
- R10: A frame start clears `status_o`, `cyc_kind_o`, `cyc_write_o` and `size_o` in the next clock and restarts header capture. A cycle cut short this way produces no `done_o`.
- R11: `done_o` lasts exactly one clock, one clock after the ending nibble. Outputs then stay unchanged, and further nibbles are ignored, until the next frame start.
- R12: Nibbles are taken only when `phase_i` is 1 (header) or 2 (SYNC), and only in the matching stage. Cycles with `phase_i` 0 or 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start_i | input | 1 | One-clock strobe that opens a new cycle |
| lad_i | input | 4 | Bus nibble |
| phase_i | input | 2 | Nibble qualifier: 1 header, 2 SYNC, 0/3 ignore |
| cyc_kind_o | output | 2 | Captured cycle kind |
| cyc_write_o | output | 1 | Captured direction, 1 = write |
| size_o | output | 2 | Captured size code |
| status_o | output | 3 | Outcome code (0 none … 6 timeout) |
| done_o | output | 1 | One-clock outcome pulse |

## Verification
The assertions assume that `phase_i` only marks nibbles that really belong to the stage it names, and that `frame_start_i` is a single-clock strobe. They then tie each reported outcome to the nibble sampled one clock earlier. The stimulus drives `phase_i` only with the defined codes. It places random ignore-phase cycles between nibbles, but never between the ending nibble and the outcome check. It asserts a frame start only at the start of a cycle, or on purpose in the middle of one to test the restart.

// File: rtl/lpc_trk_pkg.sv
package lpc_trk_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_SYNC = 2'd2,
    PH_RSVD = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    K_IO   = 2'd0,
    K_MEM  = 2'd1,
    K_DMA  = 2'd2,
    K_RSVD = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_NONE    = 3'd0,
    ST_OK      = 3'd1,
    ST_OK_MORE = 3'd2,
    ST_ERR     = 3'd3,
    ST_PROTO   = 3'd4,
    ST_ABORT   = 3'd5,
    ST_TIMEOUT = 3'd6
  } status_e;

  localparam logic [NIB_W-1:0] SY_READY = 4'h0;
  localparam logic [NIB_W-1:0] SY_SHORT = 4'h5;
  localparam logic [NIB_W-1:0] SY_LONG  = 4'h6;
  localparam logic [NIB_W-1:0] SY_MORE  = 4'h9;
  localparam logic [NIB_W-1:0] SY_FAULT = 4'hA;

  localparam logic [1:0] SZ_RSVD = 2'b10;
endpackage

// File: rtl/lpc_hdr_decode.sv
module lpc_hdr_decode
  import lpc_trk_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [1:0]       kind_o,
  output logic             write_o,
  output logic             type_bad_o,
  output logic [1:0]       size_o,
  output logic             size_bad_o
);
  always_comb begin
    kind_o     = nib_i[3:2];
    write_o    = nib_i[1];
    type_bad_o = (nib_i[3:2] == K_RSVD) || nib_i[0];
    size_o     = nib_i[1:0];
    size_bad_o = (nib_i[1:0] == SZ_RSVD);
  end
endmodule

// File: rtl/lpc_sync_classify.sv
module lpc_sync_classify
  import lpc_trk_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  input  logic             is_dma_i,
  output logic             short_o,
  output logic             long_o,
  output logic             term_o,
  output status_e          term_status_o
);
  always_comb begin
    short_o       = 1'b0;
    long_o        = 1'b0;
    term_o        = 1'b1;
    term_status_o = ST_PROTO;
    unique case (nib_i)
      SY_READY: term_status_o = ST_OK;
      SY_SHORT: begin short_o = 1'b1; term_o = 1'b0; end
      SY_LONG:  begin long_o  = 1'b1; term_o = 1'b0; end
      SY_MORE:  term_status_o = is_dma_i ? ST_OK_MORE : ST_PROTO;
      SY_FAULT: term_status_o = ST_ERR;
      default:  term_status_o = ST_PROTO;
    endcase
  end
endmodule

// File: rtl/lpc_wait_timer.sv
module lpc_wait_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lpc_sync_tracker.sv
module lpc_sync_tracker
  import lpc_trk_pkg::*;
#(
  parameter int SHORT_WAIT_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start_i,
  input  logic [3:0] lad_i,
  input  logic [1:0] phase_i,
  output logic [1:0] cyc_kind_o,
  output logic       cyc_write_o,
  output logic [1:0] size_o,
  output logic [2:0] status_o,
  output logic       done_o
);
  typedef enum logic [1:0] {S_IDLE, S_TYPE, S_SIZE, S_SYNC} fsm_e;

  fsm_e       st_q;
  logic [1:0] kind_q, size_q;
  logic       wr_q, done_q;
  status_e    status_q;

  logic       hdr_v, sync_v;
  logic [1:0] d_kind, d_size;
  logic       d_wr, d_type_bad, d_size_bad;
  logic       s_short, s_long, s_term, t_expire, t_clear, t_tick;
  status_e    s_status;

  assign hdr_v  = (phase_i == PH_HDR);
  assign sync_v = (phase_i == PH_SYNC) && (st_q == S_SYNC);

  lpc_hdr_decode u_hdr (
    .nib_i(lad_i), .kind_o(d_kind), .write_o(d_wr), .type_bad_o(d_type_bad),
    .size_o(d_size), .size_bad_o(d_size_bad)
  );

  lpc_sync_classify u_sync (
    .nib_i(lad_i), .is_dma_i(kind_q == K_DMA), .short_o(s_short),
    .long_o(s_long), .term_o(s_term), .term_status_o(s_status)
  );

  assign t_clear = frame_start_i || (st_q != S_SYNC) || (sync_v && s_long);
  assign t_tick  = !frame_start_i && sync_v && s_short;

  lpc_wait_timer #(.LIMIT(SHORT_WAIT_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(t_clear), .tick_i(t_tick), .expire_o(t_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      kind_q   <= '0;
      wr_q     <= 1'b0;
      size_q   <= '0;
      status_q <= ST_NONE;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (frame_start_i) begin
        st_q     <= S_TYPE;
        kind_q   <= '0;
        wr_q     <= 1'b0;
        size_q   <= '0;
        status_q <= ST_NONE;
      end else begin
        unique case (st_q)
          S_TYPE: if (hdr_v) begin
            kind_q <= d_kind;
            wr_q   <= d_wr;
            if (d_type_bad) begin
              status_q <= ST_ABORT;
              done_q   <= 1'b1;
              st_q     <= S_IDLE;
            end else begin
              st_q <= S_SIZE;
            end
          end
          S_SIZE: if (hdr_v) begin
            size_q <= d_size;
            if (d_size_bad) begin
              status_q <= ST_ABORT;
              done_q   <= 1'b1;
              st_q     <= S_IDLE;
            end else begin
              st_q <= S_SYNC;
            end
          end
          S_SYNC: if (sync_v) begin
            if (s_term) begin
              status_q <= s_status;
              done_q   <= 1'b1;
              st_q     <= S_IDLE;
            end else if (t_expire) begin
              status_q <= ST_TIMEOUT;
              done_q   <= 1'b1;
              st_q     <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cyc_kind_o  = kind_q;
  assign cyc_write_o = wr_q;
  assign size_o      = size_q;
  assign status_o    = status_q;
  assign done_o      = done_q;
endmodule

// File: rtl/lpc_sync_tracker_chk.sv
module lpc_sync_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start_i,
  input logic [3:0] lad_i,
  input logic [1:0] phase_i,
  input logic [1:0] cyc_kind_o,
  input logic [1:0] size_o,
  input logic [2:0] status_o,
  input logic       done_o
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start_i && status_o != 3'd0) |=> ($stable(status_o) && !done_o));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (status_o == 3'd0 && !done_o));

  p_ready_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 3'd1) |-> ($past(lad_i) == 4'h0 && $past(phase_i) == 2'd2));

  p_more_on_dma_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 3'd2) |-> cyc_kind_o == 2'd2);

  p_fault_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 3'd3) |-> $past(lad_i) == 4'hA);

  p_abort_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 3'd5) |-> (cyc_kind_o == 2'd3 || size_o == 2'd2 || $past(lad_i[0])));

  p_timeout_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && status_o == 3'd6) |-> ($past(lad_i) == 4'h5 && $past(phase_i) == 2'd2));
endmodule

bind lpc_sync_tracker lpc_sync_tracker_chk u_chk (.*);

// File: tb/sim_lpc_sync_tracker.sv
`timescale 1ns/1ps
module sim_lpc_sync_tracker;
  localparam int LIMIT = 8;

  logic       clk = 1'b0, rst_n = 1'b0, fs = 1'b0;
  logic [3:0] lad = 4'h0;
  logic [1:0] ph = 2'd0;
  logic [1:0] kind, size;
  logic       wr, done;
  logic [2:0] status;

  int n_chk = 0, n_bad = 0;
  logic [3:0] sq [0:39];
  int sq_n = 0;

  always #2 clk = ~clk;

  lpc_sync_tracker #(.SHORT_WAIT_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start_i(fs), .lad_i(lad), .phase_i(ph),
    .cyc_kind_o(kind), .cyc_write_o(wr), .size_o(size), .status_o(status), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit f, input logic [3:0] n, input logic [1:0] p);
    @(negedge clk);
    fs = f; lad = n; ph = p;
    @(posedge clk);
    #1;
  endtask

  task automatic filler(inout bit early);
    int k = $urandom_range(0, 2);
    for (int i = 0; i < k; i++) begin
      drive(1'b0, 4'($urandom), ($urandom_range(0, 1) != 0) ? 2'd3 : 2'd0);
      if (done) early = 1'b1;
    end
  endtask

  function automatic void predict(input logic [3:0] t, input logic [3:0] s,
                                  output int st, output int stage, output int idx);
    int sw = 0;
    st = 0; stage = 2; idx = 0;
    if (t[3:2] == 2'b11 || t[0]) begin stage = 0; st = 5; return; end
    if (s[1:0] == 2'b10) begin stage = 1; st = 5; return; end
    for (int i = 0; i < sq_n; i++) begin
      idx = i;
      case (sq[i])
        4'h0: begin st = 1; return; end
        4'h5: begin sw++; if (sw == LIMIT) begin st = 6; return; end end
        4'h6: sw = 0;
        4'h9: begin st = (t[3:2] == 2'b10) ? 2 : 4; return; end
        4'hA: begin st = 3; return; end
        default: begin st = 4; return; end
      endcase
    end
  endfunction

  task automatic run_cycle(input logic [3:0] t, input logic [3:0] s, input string tag);
    int st, stage, idx;
    bit early = 1'b0;
    predict(t, s, st, stage, idx);
    drive(1'b1, 4'($urandom), 2'($urandom));
    chk(status == 3'd0 && !done, "R10", "status after frame start", status, 0);
    drive(1'b0, t, 2'd1);
    if (stage > 0) begin
      if (done) early = 1'b1;
      filler(early);
      drive(1'b0, s, 2'd1);
      if (stage > 1) begin
        if (done) early = 1'b1;
        filler(early);
        for (int i = 0; i <= idx; i++) begin
          drive(1'b0, sq[i], 2'd2);
          if (i < idx) begin
            if (done) early = 1'b1;
            filler(early);
          end
        end
      end
    end
    chk(!early, "R12", "done before ending nibble", int'(early), 0);
    chk(done == 1'b1, tag, "done pulse", done, 1);
    chk(status == 3'(st), tag, "status", status, st);
    chk(kind == t[3:2] && wr == t[1], "R2", "kind/write", {kind, wr}, {t[3:2], t[1]});
    chk(size == ((stage == 0) ? 2'd0 : s[1:0]), "R4", "size", size, (stage == 0) ? 0 : s[1:0]);
    drive(1'b0, 4'($urandom), 2'd2);
    chk(!done && status == 3'(st), "R11", "hold after done", {done, status}, st);
  endtask

  function automatic logic [3:0] rand_sync();
    int r = $urandom_range(0, 99);
    if (r < 40) return 4'h5;
    if (r < 60) return 4'h6;
    if (r < 70) return 4'h0;
    if (r < 80) return 4'h9;
    if (r < 88) return 4'hA;
    return 4'($urandom);
  endfunction

  function automatic void load(input int n, input logic [3:0] v);
    for (int i = 0; i < n; i++) sq[i] = v;
    sq_n = n;
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(status == 0 && !done && kind == 0 && !wr && size == 0, "R1", "reset outputs",
        {status, done, kind, wr, size}, 0);
    @(negedge clk); rst_n = 1'b1;

    load(1, 4'h0);                          run_cycle(4'h4, 4'h3, "R5");
    load(7, 4'h5); sq[7] = 4'h0; sq_n = 8;  run_cycle(4'h2, 4'h0, "R9");
    load(9, 4'h5);                          run_cycle(4'h0, 4'h1, "R9");
    load(20, 4'h6); for (int i = 20; i < 27; i++) sq[i] = 4'h5;
    sq[27] = 4'h0; sq_n = 28;               run_cycle(4'h6, 4'h3, "R9");
    load(1, 4'h9);                          run_cycle(4'h4, 4'h0, "R6");
    load(1, 4'h9);                          run_cycle(4'hA, 4'h0, "R6");
    load(1, 4'hA);                          run_cycle(4'h8, 4'h1, "R7");
    load(1, 4'h3);                          run_cycle(4'h0, 4'h0, "R8");
    load(1, 4'h0);                          run_cycle(4'hC, 4'h0, "R3");
    load(1, 4'h0);                          run_cycle(4'h5, 4'h0, "R3");
    load(1, 4'h0);                          run_cycle(4'h0, 4'h6, "R4");
    load(1, 4'h0);                          run_cycle(4'h2, 4'hD, "R4");

    // R10: restart in the middle of a SYNC sequence
    drive(1'b1, 4'h0, 2'd0);
    drive(1'b0, 4'h4, 2'd1);
    drive(1'b0, 4'h3, 2'd1);
    drive(1'b0, 4'h5, 2'd2);
    drive(1'b0, 4'h6, 2'd2);
    chk(!done && status == 0, "R10", "no outcome before restart", {done, status}, 0);
    drive(1'b1, 4'h0, 2'd2);
    chk(!done && status == 0 && kind == 0, "R10", "abandoned cycle silent", {done, status, kind}, 0);
    load(1, 4'h0);                          run_cycle(4'h8, 4'h0, "R10");

    for (int c = 0; c < 300; c++) begin
      logic [3:0] t;
      t = {2'($urandom_range(0, 3)), 1'($urandom), ($urandom_range(0, 9) == 0) ? 1'b1 : 1'b0};
      sq_n = $urandom_range(1, 30);
      for (int i = 0; i < sq_n; i++) sq[i] = rand_sync();
      sq[sq_n - 1] = 4'h0;
      run_cycle(t, 4'($urandom), "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule